// File: doc/BRIEF.md
# SPI Command and Register Slave

This block is the host-facing side of an image sensor. It is an SPI slave in mode 0 (clock idles low, data sampled on the rising edge, most significant bit first). Its own clock `clk_i` oversamples the SPI pins through synchronizers. Each byte received while chip select is low is taken as a one-byte command unless a register-write command is in progress. The block gives access to an 18-entry file of 8-bit registers. It returns a status byte taken from an input vector and hands out image bytes from a pixel source that uses a valid/pop handshake. It also issues single-cycle pulses that start a scan and that soft-reset the register file.

Returned data lags by one byte: the byte requested by a command is shifted out on MISO while the host shifts in the next byte. A read sequence therefore ends with a dummy byte. Read, status, pixel, start and soft-reset commands can be chained within one chip-select frame. A register write takes every remaining byte in its frame as data.

Top module: `spi_cmd_slave`

## Requirements
- R1: Bytes are received MSB first on rising SCLK edges while CSn is low, and MISO presents the response byte MSB first. The first byte of a frame, and the byte after any command with no read data, returns 0x00.
- R2: Command 0x4N (bits 7:4 = 0x4) writes the following bytes of the frame to registers N, N+1, N+2 and so on. Data bytes aimed at addresses above 0x11 are dropped. Every byte of the sequence returns 0x00.
- R3: Command 0x80|A (bits 7:5 = 100, A in bits 4:0) returns register A on the next byte. For A above 0x11 it returns 0x00.
- R4: Command 0x03 returns `status_i` on the next byte, as sampled when the command byte completes.
- R5: Command 0x01 pops one byte from the pixel source when `pix_valid_i` is high and returns that byte on the next byte. When `pix_valid_i` is low it pops nothing and returns 0x00.
- R6: Command 0x02 takes no data byte and produces exactly one single-cycle `start_o` pulse.
- R7: Command 0x04 takes no data byte. It produces one single-cycle `soft_rst_o` pulse and returns every register to its default. The command decoder is not reset: later commands in the same frame still act.
- R8: After `rst_ni` every register reads 0x00, except register 0x08, which reads 0xFF, and register 0x0B, which reads 0x15 (the required operating-mode value in bits 4:0).
- R9: Read-type commands (0x01, 0x03, 0x80|A) can be chained in one frame. Each one's data appears on the byte that follows it.
- R10: A rising CSn discards any partial byte and returns the decoder to expecting a command, which also ends a register write. A CSn rise seen in the same cycle as the last SCLK edge of a byte discards that byte as well.
- R11: Any other command code has no effect and returns 0x00 on the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock from host |
| mosi_i | input | 1 | SPI data from host |
| csn_i | input | 1 | SPI chip select, active low |
| miso_o | output | 1 | SPI data to host |
| status_i | input | 8 | Status flags (bit 0 image ready, bit 6 detection OK) |
| pix_data_i | input | 8 | Current pixel byte from source |
| pix_valid_i | input | 1 | Pixel source holds a byte |
| pix_pop_o | output | 1 | Consume the current pixel byte |
| start_o | output | 1 | Scan start pulse |
| soft_rst_o | output | 1 | Soft reset pulse |
| regs_o | output | 144 | Register file, register i at bits 8*i+7:8*i |

## Verification
A chip-select rise and the completion of a byte can both be detected in the same clock cycle. When that happens, the frame end must win and the byte must have no effect. The bench provokes this by raising SCLK for the eighth bit of a 0x02 command at the same instant it raises CSn. The two signals pass through synchronizers of equal depth, so both edges are detected together. The check is that the count of `start_o` pulses does not change. A second pairing is a soft reset followed in the same frame by a register read. The bench judges it by requiring that the read returns the default value and not the value written before the reset.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int NUM_REGS = 18;
  localparam int REG_AW   = 5;
  localparam int SYNC_LEN = 2;

  localparam logic [7:0] CMD_PIX   = 8'h01;
  localparam logic [7:0] CMD_START = 8'h02;
  localparam logic [7:0] CMD_STAT  = 8'h03;
  localparam logic [7:0] CMD_SRST  = 8'h04;
  localparam logic [3:0] WR_PFX    = 4'h4;
  localparam logic [2:0] RD_PFX    = 3'b100;

  typedef enum logic {DEC_CMD, DEC_WR} dec_state_e;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      8:       return 8'hFF;
      11:      return 8'h15;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [NUM_REGS*8-1:0] default_image();
    logic [NUM_REGS*8-1:0] img;
    for (int i = 0; i < NUM_REGS; i++) img[8*i +: 8] = reg_default(i);
    return img;
  endfunction
endpackage

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int SyncLen = spi_cmd_pkg::SYNC_LEN
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic       csn_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_byte_i,
  output logic       byte_vld_o,
  output logic [7:0] rx_byte_o,
  output logic       frame_end_o,
  output logic       miso_o
);
  logic [SyncLen-1:0] sclk_s, mosi_s, csn_s;
  logic sclk_prev, csn_prev;
  logic sclk_q, mosi_q, csn_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] out_q;
  logic sclk_rise, cs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s    <= '0;
      mosi_s    <= '0;
      csn_s     <= '1;
      sclk_prev <= 1'b0;
      csn_prev  <= 1'b1;
    end else begin
      sclk_s    <= {sclk_s[SyncLen-2:0], sclk_i};
      mosi_s    <= {mosi_s[SyncLen-2:0], mosi_i};
      csn_s     <= {csn_s[SyncLen-2:0], csn_i};
      sclk_prev <= sclk_q;
      csn_prev  <= csn_q;
    end
  end

  assign sclk_q = sclk_s[SyncLen-1];
  assign mosi_q = mosi_s[SyncLen-1];
  assign csn_q  = csn_s[SyncLen-1];

  // frame end has priority over a byte finishing in the same cycle
  assign sclk_rise = sclk_q & ~sclk_prev & ~csn_q;
  assign cs_rise   = csn_q & ~csn_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (csn_q) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      rx_sh   <= {rx_sh[5:0], mosi_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        out_q <= '0;
    else if (csn_q)     out_q <= '0;
    else if (tx_load_i) out_q <= tx_byte_i;
  end

  assign byte_vld_o  = sclk_rise & (bit_cnt == 3'd7);
  assign rx_byte_o   = {rx_sh, mosi_q};
  assign frame_end_o = cs_rise;
  assign miso_o      = out_q[3'd7 - bit_cnt];
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int NumRegs = NUM_REGS,
  parameter int AddrW   = REG_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             frame_end_i,
  input  logic [7:0]       status_i,
  input  logic [7:0]       pix_data_i,
  input  logic             pix_valid_i,
  input  logic [7:0]       rd_data_i,
  output logic [AddrW-1:0] rd_addr_o,
  output logic [7:0]       tx_byte_o,
  output logic             pix_pop_o,
  output logic             start_o,
  output logic             soft_rst_o,
  output logic             wr_en_o,
  output logic [AddrW-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o
);
  dec_state_e st_q;
  logic [AddrW-1:0] ptr_q;
  logic is_cmd;

  assign is_cmd    = byte_vld_i && (st_q == DEC_CMD);
  assign rd_addr_o = rx_byte_i[AddrW-1:0];

  always_comb begin
    tx_byte_o = '0;
    pix_pop_o = 1'b0;
    if (is_cmd) begin
      if (rx_byte_i == CMD_PIX) begin
        if (pix_valid_i) begin
          tx_byte_o = pix_data_i;
          pix_pop_o = 1'b1;
        end
      end else if (rx_byte_i == CMD_STAT) begin
        tx_byte_o = status_i;
      end else if (rx_byte_i[7:5] == RD_PFX) begin
        tx_byte_o = rd_data_i;
      end
    end
  end

  assign wr_en_o   = byte_vld_i && (st_q == DEC_WR) && (ptr_q < AddrW'(NumRegs));
  assign wr_addr_o = ptr_q;
  assign wr_data_o = rx_byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DEC_CMD;
      ptr_q <= '0;
    end else if (frame_end_i) begin
      st_q <= DEC_CMD;
    end else if (byte_vld_i) begin
      if (st_q == DEC_CMD) begin
        if (rx_byte_i[7:4] == WR_PFX) begin
          st_q  <= DEC_WR;
          ptr_q <= AddrW'(rx_byte_i[3:0]);
        end
      end else if (ptr_q != '1) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o    <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      start_o    <= is_cmd && (rx_byte_i == CMD_START);
      soft_rst_o <= is_cmd && (rx_byte_i == CMD_SRST);
    end
  end
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
  import spi_cmd_pkg::*;
#(
  parameter int NumRegs = NUM_REGS,
  parameter int AddrW   = REG_AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 soft_rst_i,
  input  logic                 wr_en_i,
  input  logic [AddrW-1:0]     wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [AddrW-1:0]     rd_addr_i,
  output logic [7:0]           rd_data_o,
  output logic [NumRegs*8-1:0] regs_o
);
  logic [7:0] mem [NumRegs];

  for (genvar g = 0; g < NumRegs; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[g] <= reg_default(g);
      else if (soft_rst_i)                            mem[g] <= reg_default(g);
      else if (wr_en_i && (wr_addr_i == AddrW'(g)))   mem[g] <= wr_data_i;
    end
    assign regs_o[8*g +: 8] = mem[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NumRegs; i++)
      if (rd_addr_i == AddrW'(i)) rd_data_o = mem[i];
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int NumRegs = NUM_REGS,
  parameter int SyncLen = SYNC_LEN
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 mosi_i,
  input  logic                 csn_i,
  output logic                 miso_o,
  input  logic [7:0]           status_i,
  input  logic [7:0]           pix_data_i,
  input  logic                 pix_valid_i,
  output logic                 pix_pop_o,
  output logic                 start_o,
  output logic                 soft_rst_o,
  output logic [NumRegs*8-1:0] regs_o
);
  localparam int AddrW = REG_AW;

  logic             byte_vld, frame_end, wr_en;
  logic [7:0]       rx_byte, tx_byte, wr_data, rd_data;
  logic [AddrW-1:0] wr_addr, rd_addr;

  spi_cmd_shifter #(.SyncLen(SyncLen)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .mosi_i     (mosi_i),
    .csn_i      (csn_i),
    .tx_load_i  (byte_vld),
    .tx_byte_i  (tx_byte),
    .byte_vld_o (byte_vld),
    .rx_byte_o  (rx_byte),
    .frame_end_o(frame_end),
    .miso_o     (miso_o)
  );

  spi_cmd_decoder #(.NumRegs(NumRegs), .AddrW(AddrW)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .rx_byte_i  (rx_byte),
    .frame_end_i(frame_end),
    .status_i   (status_i),
    .pix_data_i (pix_data_i),
    .pix_valid_i(pix_valid_i),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .tx_byte_o  (tx_byte),
    .pix_pop_o  (pix_pop_o),
    .start_o    (start_o),
    .soft_rst_o (soft_rst_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  spi_cmd_regfile #(.NumRegs(NumRegs), .AddrW(AddrW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_o),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk
  import spi_cmd_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  csn_i,
  input logic                  start_o,
  input logic                  soft_rst_o,
  input logic                  pix_pop_o,
  input logic [NUM_REGS*8-1:0] regs_o
);
  // R6: start is a single-cycle pulse
  a_r6_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R5: one pop per command byte
  a_r5_pop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_pop_o |=> !pix_pop_o);

  // R7: defaults restored on the cycle after the soft reset pulse
  a_r7_soft_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (regs_o == default_image()));

  // R10: no command effect while chip select is held high
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3))
      |-> !(start_o || soft_rst_o || pix_pop_o));

  // R11: one command byte produces at most one action
  a_r11_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, soft_rst_o, pix_pop_o}));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .csn_i     (csn_i),
  .start_o   (start_o),
  .soft_rst_o(soft_rst_o),
  .pix_pop_o (pix_pop_o),
  .regs_o    (regs_o)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4 * CLK_PERIOD;
  localparam int NREG       = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic miso, pix_pop, start, srst;
  logic [7:0] status = 8'h41;
  logic [7:0] pix_data;
  logic pix_valid = 1'b0;
  logic [NREG*8-1:0] regs;

  logic [7:0] pix_cnt;
  int start_cnt, srst_cnt;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .csn_i(csn),
    .miso_o(miso), .status_i(status), .pix_data_i(pix_data),
    .pix_valid_i(pix_valid), .pix_pop_o(pix_pop), .start_o(start),
    .soft_rst_o(srst), .regs_o(regs)
  );

  assign pix_data = 8'hA0 + pix_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt <= '0; start_cnt <= 0; srst_cnt <= 0;
    end else begin
      if (pix_pop) pix_cnt <= pix_cnt + 8'd1;
      if (start)   start_cnt <= start_cnt + 1;
      if (srst)    srst_cnt <= srst_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      #(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_begin();
    csn = 1'b0;
    #(HALF);
    exp_q.push_back(8'h00);
    req_q.push_back("R1");
  endtask

  task automatic frame_end();
    #(HALF);
    csn = 1'b1;
    #(2*HALF);
    exp_q.delete();
    req_q.delete();
  endtask

  // driver: sends a byte, queues the response expected on the next byte;
  // scoreboard side: pops the expectation for this byte and compares
  task automatic send(input logic [7:0] cmd, input logic [7:0] nxt, input string nreq);
    logic [7:0] rx;
    xbits(cmd, 8, rx);
    #(HALF);
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(rx == e, r, rx, e);
    end
    exp_q.push_back(nxt);
    req_q.push_back(nreq);
  endtask

  function automatic logic [7:0] reg_at(input int a);
    return regs[8*a +: 8];
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    #(3*CLK_PERIOD);
    rst_n = 1'b1;
    #(3*CLK_PERIOD);

    // R8: reset defaults
    for (int a = 0; a < NREG; a++) begin
      logic [7:0] e;
      e = (a == 8) ? 8'hFF : (a == 11) ? 8'h15 : 8'h00;
      check(reg_at(a) == e, "R8", reg_at(a), e);
    end
    check(miso == 1'b0 && !start && !srst && !pix_pop, "R8 idle outputs", miso, 0);

    // R4 status read, R1 first byte zero
    frame_begin();
    send(8'h03, 8'h41, "R4");
    send(8'h00, 8'h00, "R11");
    frame_end();

    // R2 auto-increment write, overflow beyond 0x11 dropped
    frame_begin();
    send(8'h4E, 8'h00, "R2");
    send(8'h11, 8'h00, "R2");
    send(8'h22, 8'h00, "R2");
    send(8'h33, 8'h00, "R2");
    send(8'h44, 8'h00, "R2");
    send(8'h55, 8'h00, "R2");
    frame_end();
    check(reg_at(14) == 8'h11, "R2", reg_at(14), 8'h11);
    check(reg_at(15) == 8'h22, "R2", reg_at(15), 8'h22);
    check(reg_at(16) == 8'h33, "R2", reg_at(16), 8'h33);
    check(reg_at(17) == 8'h44, "R2", reg_at(17), 8'h44);
    check(reg_at(0) == 8'h00, "R2 dropped", reg_at(0), 8'h00);

    // R3 / R9 chained register reads, out-of-range address
    frame_begin();
    send(8'h8E, 8'h11, "R3");
    send(8'h90, 8'h33, "R9");
    send(8'h91, 8'h44, "R9");
    send(8'h92, 8'h00, "R3 out of range");
    send(8'h88, 8'hFF, "R3");
    send(8'h8B, 8'h15, "R3");
    send(8'h00, 8'h00, "R11");
    frame_end();

    // R5 pixel stream, mixed with status read (R9)
    pix_valid = 1'b1;
    frame_begin();
    send(8'h01, 8'hA0, "R5");
    send(8'h01, 8'hA1, "R5");
    send(8'h03, 8'h41, "R9");
    send(8'h01, 8'hA2, "R5");
    send(8'h00, 8'h00, "R11");
    frame_end();
    check(pix_cnt == 8'd3, "R5 pops", pix_cnt, 3);
    pix_valid = 1'b0;
    frame_begin();
    send(8'h01, 8'h00, "R5 empty");
    send(8'h00, 8'h00, "R11");
    frame_end();
    check(pix_cnt == 8'd3, "R5 no pop", pix_cnt, 3);

    // R6 start
    frame_begin();
    send(8'h02, 8'h00, "R6");
    send(8'h03, 8'h41, "R6");
    send(8'h00, 8'h00, "R11");
    frame_end();
    check(start_cnt == 1, "R6", start_cnt, 1);

    // R7 soft reset keeps decoder running
    frame_begin();
    send(8'h43, 8'h00, "R2");
    send(8'h77, 8'h00, "R2");
    frame_end();
    check(reg_at(3) == 8'h77, "R2", reg_at(3), 8'h77);
    frame_begin();
    send(8'h04, 8'h00, "R7");
    send(8'h83, 8'h00, "R7");
    send(8'h8F, 8'h00, "R7");
    send(8'h00, 8'h00, "R11");
    frame_end();
    check(srst_cnt == 1, "R7", srst_cnt, 1);
    check(reg_at(8) == 8'hFF && reg_at(11) == 8'h15, "R7", reg_at(11), 8'h15);

    // R10 partial byte aborted
    frame_begin();
    xbits(8'h02, 4, junk);
    frame_end();
    check(start_cnt == 1, "R10 partial", start_cnt, 1);

    // R10 write ended by frame, R11 unknown code as command
    frame_begin();
    send(8'h45, 8'h00, "R2");
    send(8'h66, 8'h00, "R2");
    frame_end();
    frame_begin();
    send(8'h55, 8'h00, "R11");
    send(8'h00, 8'h00, "R11");
    frame_end();
    check(reg_at(5) == 8'h66, "R2", reg_at(5), 8'h66);
    check(reg_at(6) == 8'h00, "R10 write ended", reg_at(6), 8'h00);

    // R10 frame end coincides with last bit of a start command
    frame_begin();
    xbits(8'h02, 7, junk);
    mosi = 1'b0;
    #(HALF);
    sclk = 1'b1;
    csn  = 1'b1;
    #(HALF);
    sclk = 1'b0;
    #(2*HALF);
    exp_q.delete(); req_q.delete();
    check(start_cnt == 1, "R10 coincident", start_cnt, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule